// File: doc/BRIEF.md
# USB Host Port Status and Control Register

This block keeps the host-side view of one USB port: whether a device is attached, whether a new connection has been seen and not yet acknowledged, and whether the port is enabled for traffic. Line-state detection, the reset signalling timer and the PHY sit outside it. They report to it through four single-cycle event pulses: connect, disconnect, overcurrent and reset-sequence-complete. Software reaches the state through a plain word-addressed register interface. Writes take effect at the next clock edge, and reads are combinational from the read address.

The port-enable bit has asymmetric rights. Only hardware can set it, when a reset sequence completes on an attached port. Software can only clear it, and faults clear it on their own. The connect-detected flag is sticky and is acknowledged by writing 1 to it. The pending sticky flags are ORed into a host-port interrupt line. A global enable bit in a control word masks that line. The unmasked summary can be read at its own address.

All three words are interfaces of control and status only. They carry no data stream, so no valid/ready handshake is needed. Every pin is a plain level or a one-cycle pulse.

Top module: `usb_hport_ctl`

## Requirements
- R1: After a synchronous active-low reset, every register bit reads 0 and `irq_hport` is 0.
- R2: The attached bit (word 0, bit 0) becomes 1 after a connect pulse and 0 after a disconnect pulse. If both pulses arrive in the same cycle, it becomes 0.
- R3: The connect-detected bit (word 0, bit 1) becomes 1 after a connect pulse and stays 1 until software clears it.
- R4: A write to word 0 with bit 1 set clears connect-detected. A write with bit 1 clear leaves it unchanged.
- R5: If a connect pulse and a write-1 clear of connect-detected fall in the same cycle, connect-detected ends at 1.
- R6: The port-enable bit (word 0, bit 2) becomes 1 only after a reset-complete pulse, and only when the attached bit was already 1 before that edge. No write can set it. A write to word 0 with bit 2 set clears it.
- R7: An overcurrent or disconnect pulse clears port-enable. Either one wins over a reset-complete pulse in the same cycle.
- R8: Changes of port-enable affect neither `irq_hport` nor the summary word.
- R9: Word 2, bit 0 reads the OR of the pending sticky flags. `irq_hport` equals that OR gated by the global enable (word 1, bit 0).
- R10: Word 1, bit 0 is read/write. Reserved bits of every word read 0, and unmapped word addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_connect | input | 1 | Device connection detected (one-cycle pulse) |
| ev_disconnect | input | 1 | Device disconnection detected (one-cycle pulse) |
| ev_overcurrent | input | 1 | Overcurrent fault (one-cycle pulse) |
| ev_reset_done | input | 1 | Port reset sequence completed (one-cycle pulse) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address for the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address for the read |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| irq_hport | output | 1 | Host-port interrupt to the top-level summary |

## Verification
The event pulses and a software write to the port word can land on the same clock edge. This matters most where a connect collides with a write-1 acknowledge, and where a reset-complete collides with a fault or a software clear of port-enable. The bench provokes these collisions by putting the port into each reachable state of attached, connect-detected and enabled. From there it applies every combination of the four event pulses together with the two clear bits of a port-word write, under both settings of the global enable. Each outcome is judged against a next-state rule computed in the bench from the stated priorities. The bench compares the full port word, the summary word and the interrupt line.

// File: rtl/usb_hport_pkg.sv
package usb_hport_pkg;
  // Bit positions inside the port word; software decodes these
  localparam int unsigned PB_ATTACHED = 0;
  localparam int unsigned PB_CONNDET  = 1;
  localparam int unsigned PB_ENABLE   = 2;

  // Bit position of the global interrupt enable in the control word
  localparam int unsigned CB_GIE      = 0;

  // Number of sticky port flags feeding the interrupt summary
  localparam int unsigned N_FLAGS     = 1;
  localparam int unsigned FL_CONNDET  = 0;

  // Word addresses
  typedef enum logic [1:0] {
    W_PORT   = 2'd0,
    W_CTRL   = 2'd1,
    W_INTSUM = 2'd2
  } word_sel_e;

  typedef struct packed {
    logic connect;
    logic disconnect;
    logic overcurrent;
    logic reset_done;
  } port_ev_t;

  typedef struct packed {
    logic clr_conndet;
    logic clr_enable;
    logic wr_ctrl;
    logic gie_val;
  } sw_req_t;
endpackage

// File: rtl/hport_link_state.sv
module hport_link_state
  import usb_hport_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  port_ev_t ev,
  input  logic     sw_clr_en,
  output logic     attached,
  output logic     port_en
);
  logic att_nx;
  logic en_nx;
  logic en_kill;
  logic en_grant;

  // A disconnect overrides a connect in the same cycle
  always_comb begin
    att_nx = attached;
    if (ev.connect)    att_nx = 1'b1;
    if (ev.disconnect) att_nx = 1'b0;
  end

  // Enable is granted only by hardware on an already attached port.
  // Faults and a software clear always win over the grant.
  always_comb begin
    en_kill  = ev.overcurrent | ev.disconnect | sw_clr_en;
    en_grant = ev.reset_done & attached;
    en_nx    = port_en;
    if (en_grant) en_nx = 1'b1;
    if (en_kill)  en_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attached <= 1'b0;
      port_en  <= 1'b0;
    end else begin
      attached <= att_nx;
      port_en  <= en_nx;
    end
  end
endmodule

// File: rtl/hport_sticky_flags.sv
module hport_sticky_flags #(
  parameter int unsigned N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic         any_o
);
  // One flag per generate slot; a hardware set beats a software clear
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic nx;
    always_comb begin
      nx = flag_o[g];
      if (clr_i[g]) nx = 1'b0;
      if (set_i[g]) nx = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) flag_o[g] <= 1'b0;
      else        flag_o[g] <= nx;
    end
  end

  assign any_o = |flag_o;
endmodule

// File: rtl/hport_regif.sv
module hport_regif
  import usb_hport_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              attached,
  input  logic              port_en,
  input  logic [N_FLAGS-1:0] flags,
  input  logic              pending,
  output sw_req_t           sw,
  output logic              gie,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned SEL_W = 2;

  logic wr_port;
  logic wr_ctl;
  logic unused_wr_bits;

  always_comb begin
    wr_port = wr_en && (wr_addr == ADDR_W'(W_PORT));
    wr_ctl  = wr_en && (wr_addr == ADDR_W'(W_CTRL));
  end

  assign sw.clr_conndet = wr_port & wr_data[PB_CONNDET];
  assign sw.clr_enable  = wr_port & wr_data[PB_ENABLE];
  assign sw.wr_ctrl     = wr_ctl;
  assign sw.gie_val     = wr_data[CB_GIE];

  assign unused_wr_bits = ^{wr_data[DATA_W-1:PB_ENABLE+1], wr_data[PB_ATTACHED]};

  always_ff @(posedge clk) begin
    if (!rst_n)          gie <= 1'b0;
    else if (sw.wr_ctrl) gie <= sw.gie_val;
  end

  // Read mux; reserved and unmapped locations return zero
  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(1 << SEL_W)) begin
      case (word_sel_e'(rd_addr[SEL_W-1:0]))
        W_PORT: begin
          rd_data[PB_ATTACHED] = attached;
          rd_data[PB_CONNDET]  = flags[FL_CONNDET];
          rd_data[PB_ENABLE]   = port_en;
        end
        W_CTRL:   rd_data[CB_GIE] = gie;
        W_INTSUM: rd_data[0]      = pending;
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/usb_hport_ctl.sv
module usb_hport_ctl
  import usb_hport_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_connect,
  input  logic              ev_disconnect,
  input  logic              ev_overcurrent,
  input  logic              ev_reset_done,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_hport
);
  port_ev_t           ev;
  sw_req_t            sw;
  logic               attached;
  logic               port_en;
  logic               gie;
  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_clr;
  logic [N_FLAGS-1:0] flags;
  logic               pending;
  logic               conn_det;

  assign ev.connect     = ev_connect;
  assign ev.disconnect  = ev_disconnect;
  assign ev.overcurrent = ev_overcurrent;
  assign ev.reset_done  = ev_reset_done;

  hport_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .attached (attached),
    .port_en  (port_en),
    .flags    (flags),
    .pending  (pending),
    .sw       (sw),
    .gie      (gie),
    .rd_data  (rd_data)
  );

  hport_link_state u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .sw_clr_en (sw.clr_enable),
    .attached  (attached),
    .port_en   (port_en)
  );

  always_comb begin
    flag_set             = '0;
    flag_clr             = '0;
    flag_set[FL_CONNDET] = ev.connect;
    flag_clr[FL_CONNDET] = sw.clr_conndet;
  end

  hport_sticky_flags #(.N(N_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flags),
    .any_o  (pending)
  );

  assign conn_det  = flags[FL_CONNDET];
  assign irq_hport = pending & gie;
endmodule

// File: rtl/usb_hport_ctl_chk.sv
module usb_hport_ctl_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_connect,
  input logic              ev_disconnect,
  input logic              ev_overcurrent,
  input logic              ev_reset_done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_hport,
  input logic              attached,
  input logic              port_en,
  input logic              conn_det
);
  logic port_wr;
  assign port_wr = wr_en && (wr_addr == '0);

  // R6
  enable_from_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_en) |-> ($past(ev_reset_done) && $past(attached)));

  // R7
  fault_kills_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_overcurrent || ev_disconnect) |=> !port_en);

  // R2
  disconnect_detach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_disconnect |=> !attached);

  // R3
  connect_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_connect |=> conn_det);

  // R4
  ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && wr_data[1] && !ev_connect) |=> !conn_det);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hport |-> conn_det);

  // R8
  enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_hport) |-> ($past(ev_connect) || $past(wr_en)));
endmodule

bind usb_hport_ctl usb_hport_ctl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ev_connect     (ev_connect),
  .ev_disconnect  (ev_disconnect),
  .ev_overcurrent (ev_overcurrent),
  .ev_reset_done  (ev_reset_done),
  .wr_en          (wr_en),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .irq_hport      (irq_hport),
  .attached       (attached),
  .port_en        (port_en),
  .conn_det       (conn_det)
);

// File: tb/usb_hport_ctl_bench.sv
module usb_hport_ctl_bench;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_connect = 1'b0, ev_disconnect = 1'b0;
  logic          ev_overcurrent = 1'b0, ev_reset_done = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq_hport;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_hport_ctl #(.DATA_W(DW), .ADDR_W(AW)) u_usb_hport_ctl (
    .clk(clk), .rst_n(rst_n),
    .ev_connect(ev_connect), .ev_disconnect(ev_disconnect),
    .ev_overcurrent(ev_overcurrent), .ev_reset_done(ev_reset_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_hport(irq_hport)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    rd_addr = AW'(a);
    #1 v = rd_data;
  endtask

  // Drive a cycle of inputs at a falling edge, clear them at the next one
  task automatic step(input logic c, input logic d, input logic o, input logic r,
                      input logic we, input int a, input logic [DW-1:0] wd);
    @(negedge clk);
    ev_connect = c; ev_disconnect = d; ev_overcurrent = o; ev_reset_done = r;
    wr_en = we; wr_addr = AW'(a); wr_data = wd;
    @(negedge clk);
    ev_connect = 0; ev_disconnect = 0; ev_overcurrent = 0; ev_reset_done = 0;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    do_reset();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a, v); chk("R1 reset word", v, '0);
    end
    chk("R1 irq after reset", {31'b0, irq_hport}, '0);

    // R10 control word and reserved bits
    step(0,0,0,0, 1, 1, '1);
    rd(1, v); chk("R10 ctrl readback 1", v, 32'h1);
    rd(3, v); chk("R10 unmapped word", v, '0);
    rd(9, v); chk("R10 high unmapped word", v, '0);
    step(0,0,0,0, 1, 1, 32'hFFFF_FFFE);
    rd(1, v); chk("R10 ctrl readback 0", v, '0);
    // R6 write cannot set enable even when attached
    step(1,0,0,0, 0, 0, '0);
    step(0,0,0,0, 1, 0, 32'hFFFF_FFF9);
    rd(0, v); chk("R6 write cannot set enable", v, 32'h3);

    // Sweep: start state x event/write combination x global enable
    for (int st = 0; st < 8; st++) begin
      logic a0, c0, e0;
      a0 = st[0]; c0 = st[1]; e0 = st[2];
      if (e0 && !a0) continue;
      for (int combo = 0; combo < 128; combo++) begin
        logic c, d, o, r, w1, w2, g, we;
        logic a1, c1, e1;
        c = combo[0]; d = combo[1]; o = combo[2]; r = combo[3];
        w1 = combo[4]; w2 = combo[5]; g = combo[6];
        we = w1 | w2;
        do_reset();
        if (g) step(0,0,0,0, 1, 1, 32'h1);
        if (a0 || c0) step(1,0,0,0, 0, 0, '0);
        if (c0 && !a0) step(0,1,0,0, 0, 0, '0);
        if (e0) step(0,0,0,1, 0, 0, '0);
        if (!c0 && a0) step(0,0,0,0, 1, 0, 32'h2);
        rd(0, v); chk("R2 R3 setup state", v, {29'b0, e0, c0, a0});

        step(c, d, o, r, we, 0, {29'b0, w2, w1, 1'b1});
        a1 = d ? 1'b0 : (c ? 1'b1 : a0);
        c1 = c ? 1'b1 : (w1 ? 1'b0 : c0);
        e1 = (o | d | w2) ? 1'b0 : ((r & a0) ? 1'b1 : e0);
        rd(0, v);
        chk("R2 attached", {31'b0, v[0]}, {31'b0, a1});
        if (c && w1) chk("R5 set beats clear", {31'b0, v[1]}, {31'b0, c1});
        else if (w1) chk("R4 ack clears", {31'b0, v[1]}, {31'b0, c1});
        else chk("R3 R4 flag", {31'b0, v[1]}, {31'b0, c1});
        if (o | d) chk("R7 fault clears enable", {31'b0, v[2]}, {31'b0, e1});
        else chk("R6 enable", {31'b0, v[2]}, {31'b0, e1});
        chk("R10 port reserved", v & 32'hFFFF_FFF8, '0);
        rd(2, v); chk("R9 R8 summary word", v, {31'b0, c1});
        chk("R9 R8 irq", {31'b0, irq_hport}, {31'b0, g & c1});
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule